// File: doc/BRIEF.md
# PWM Fault Input Filter and Latch

This block is the input side of a PWM fault shutdown path. It takes two candidate fault sources: an external fault pin and the output of an analog comparator. Both sources are asynchronous, so each one is brought into the clock domain through its own two-flop synchroniser. A configuration bit picks one of the synchronised sources. The chosen signal can then go through a noise filter. The filter only moves its output level after four consecutive samples agree.

An edge detector follows the filter. It watches for a falling edge or a rising edge, as configured. A matching edge sets a sticky fault flag. The flag stays set until the CPU acknowledges the interrupt or writes a one to the clear strobe. While the flag is set, an interrupt request is raised if interrupts are enabled. In the same way, a shutdown request is held if protection mode is enabled. The PWM output stage uses the shutdown request to force its outputs inactive.

The configuration inputs come straight from a control register. The interrupt controller and the PWM output stage are outside this block.

Top module: `pwm_fault_frontend`

## Requirements
- R1: After a synchronous reset, `fault_flag_o`, `irq_o` and `shutdown_o` are 0, whatever the configuration inputs are.
- R2: With `filt_en_i`=0, a qualifying edge on the selected input shows on `fault_flag_o` after the third rising clock edge that follows the input change. Two of those edges are the synchroniser; the third is the flag register. After two edges the flag is still 0.
- R3: With `filt_en_i`=1, the level fed to the edge detector changes only after four consecutive synchronised samples agree. This adds exactly four clocks, so the flag shows after the seventh edge and is still 0 after the sixth. A pulse that lasts three samples or fewer never sets the flag.
- R4: `edge_rise_i`=0 selects falling edges and `edge_rise_i`=1 selects rising edges. An edge in the other direction leaves the flag unchanged.
- R5: `src_cmp_i`=0 selects `fault_pin_i` and `src_cmp_i`=1 selects `cmp_out_i`. The input that is not selected has no effect on the flag. The comparator path uses the same filter and edge logic as the pin path.
- R6: Once set, the flag holds until `flag_clr_i` or `irq_ack_i` is 1 at a rising edge. The flag then reads 0 after that edge.
- R7: If a fault event and a clear (`flag_clr_i` or `irq_ack_i`) fall in the same cycle, the flag is 1 after that edge.
- R8: `irq_o` is 1 exactly when the flag is 1 and `irq_en_i` is 1.
- R9: `shutdown_o` is 1 exactly when the flag is 1 and `prot_en_i` is 1. It drops in the same cycle as the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fault_pin_i | input | 1 | External fault pin, asynchronous |
| cmp_out_i | input | 1 | Analog comparator result, asynchronous |
| prot_en_i | input | 1 | Protection mode enable; lets the flag drive the shutdown request |
| filt_en_i | input | 1 | Enables the four-sample noise filter |
| edge_rise_i | input | 1 | Edge select: 0 = falling edge, 1 = rising edge |
| src_cmp_i | input | 1 | Source select: 0 = fault pin, 1 = comparator |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the fault flag |
| irq_ack_i | input | 1 | Interrupt acknowledge; clears the flag |
| fault_flag_o | output | 1 | Sticky fault flag |
| irq_o | output | 1 | Interrupt request |
| shutdown_o | output | 1 | Shutdown request to the PWM output stage |

## Verification
The assertions assume that the configuration inputs come from a register and only change on clock edges. The block may see one extra edge when the source or filter selection switches between two inputs at different levels. The reference model in the bench has the same view of the configuration, so it predicts that edge as well. For this reason, the random phases change configuration only at phase boundaries and hold it steady within each phase. Fault inputs, clears and acknowledges are driven one nanosecond after the clock edge. Fault inputs are held for runs of one to six cycles, so that pulses both shorter and longer than the filter window occur.

// File: rtl/fltfe_pkg.sv
package fltfe_pkg;

    localparam int SYNC_STAGES = 2;
    localparam int FILT_TAPS   = 4;
    localparam int NUM_SRC     = 2;

    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_CMP = 1'b1
    } src_e;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_e;

    typedef struct packed {
        logic  prot_en;
        logic  filt_en;
        edge_e edge_sel;
        src_e  src_sel;
        logic  irq_en;
    } cfg_t;

    function automatic logic edge_hit(edge_e sel, logic now_lvl, logic old_lvl);
        if (sel == EDGE_RISE) return now_lvl & ~old_lvl;
        else                  return ~now_lvl & old_lvl;
    endfunction

endpackage

// File: rtl/fltfe_sync.sv
module fltfe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/fltfe_filter.sv
module fltfe_filter #(
    parameter int TAPS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic lvl
);
    logic [TAPS-2:0] hist;
    logic [TAPS-1:0] window;
    logic            filt_q;
    logic            all_hi;
    logic            all_lo;

    assign window = {hist, din};
    assign all_hi = &window;
    assign all_lo = ~|window;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist   <= '0;
            filt_q <= 1'b0;
        end else begin
            hist <= window[TAPS-2:0];
            if (all_hi)      filt_q <= 1'b1;
            else if (all_lo) filt_q <= 1'b0;
        end
    end

    // The filter state is kept up to date even while bypassed.
    assign lvl = en ? filt_q : din;

    // R3: filtered level rises only after a full window of ones
    a_r3_rise_needs_window: assert property (@(posedge clk) disable iff (rst)
        $rose(filt_q) |-> $past(all_hi));

    // R3: filtered level falls only after a full window of zeros
    a_r3_fall_needs_window: assert property (@(posedge clk) disable iff (rst)
        $fell(filt_q) |-> $past(all_lo));
endmodule

// File: rtl/fltfe_latch.sv
module fltfe_latch
    import fltfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  lvl,
    input  edge_e edge_sel,
    input  logic  clr,
    input  logic  ack,
    output logic  flag
);
    logic prev_q;
    logic flag_q;
    logic evt;
    logic wipe;

    assign evt  = edge_hit(edge_sel, lvl, prev_q);
    assign wipe = clr | ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= lvl;
            flag_q <= evt | (flag_q & ~wipe);
        end
    end

    assign flag = flag_q;

    // R7: a new event wins over a clear in the same cycle
    a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
        evt |=> flag_q);

    // R6: a clear with no event empties the flag
    a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
        (wipe && !evt) |=> !flag_q);

    // R6: the flag is sticky while no clear arrives
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !wipe) |=> flag_q);

    // R4: the flag only rises because of a detected edge
    a_r4_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(evt));
endmodule

// File: rtl/pwm_fault_frontend.sv
module pwm_fault_frontend
    import fltfe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fault_pin_i,
    input  logic cmp_out_i,
    input  logic prot_en_i,
    input  logic filt_en_i,
    input  logic edge_rise_i,
    input  logic src_cmp_i,
    input  logic irq_en_i,
    input  logic flag_clr_i,
    input  logic irq_ack_i,
    output logic fault_flag_o,
    output logic irq_o,
    output logic shutdown_o
);
    cfg_t               cfg;
    logic [NUM_SRC-1:0] raw_vec;
    logic [NUM_SRC-1:0] sync_vec;
    logic               sel_smp;
    logic               clean_lvl;
    logic               flag;

    assign cfg = '{
        prot_en:  prot_en_i,
        filt_en:  filt_en_i,
        edge_sel: edge_e'(edge_rise_i),
        src_sel:  src_e'(src_cmp_i),
        irq_en:   irq_en_i
    };

    // Index order follows src_e: SRC_PIN = 0, SRC_CMP = 1.
    assign raw_vec = {cmp_out_i, fault_pin_i};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
        fltfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw_vec[g]),
            .q   (sync_vec[g])
        );
    end

    assign sel_smp = sync_vec[cfg.src_sel];

    fltfe_filter #(.TAPS(FILT_TAPS)) u_filter (
        .clk (clk),
        .rst (rst),
        .en  (cfg.filt_en),
        .din (sel_smp),
        .lvl (clean_lvl)
    );

    fltfe_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .lvl      (clean_lvl),
        .edge_sel (cfg.edge_sel),
        .clr      (flag_clr_i),
        .ack      (irq_ack_i),
        .flag     (flag)
    );

    assign fault_flag_o = flag;
    assign irq_o        = flag & cfg.irq_en;
    assign shutdown_o   = flag & cfg.prot_en;

    // R8: no interrupt request while interrupts are disabled
    a_r8_irq_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !irq_en_i |-> !irq_o);

    // R9: no shutdown request without a pending fault
    a_r9_shutdown_needs_flag: assert property (@(posedge clk) disable iff (rst)
        !fault_flag_o |-> !shutdown_o);

    // R1: outputs idle on the first cycle after reset
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!fault_flag_o && !irq_o && !shutdown_o));
endmodule

// File: tb/pwm_fault_frontend_test.sv
`timescale 1ns/1ps
module pwm_fault_frontend_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin = 1'b0, cmp = 1'b0;
    logic prot = 1'b0, filt = 1'b0, rise = 1'b0, srcc = 1'b0, irqen = 1'b0;
    logic clr = 1'b0, ack = 1'b0;
    logic flag, irq, sd;

    int checks   = 0;
    int failures = 0;
    logic model_on = 1'b0;

    always #5 clk = ~clk;

    pwm_fault_frontend uut (
        .clk (clk), .rst (rst),
        .fault_pin_i (pin), .cmp_out_i (cmp),
        .prot_en_i (prot), .filt_en_i (filt), .edge_rise_i (rise),
        .src_cmp_i (srcc), .irq_en_i (irqen),
        .flag_clr_i (clr), .irq_ack_i (ack),
        .fault_flag_o (flag), .irq_o (irq), .shutdown_o (sd)
    );

    // Reference model built from the requirements (R2..R7).
    logic       m_p1, m_p2, m_c1, m_c2, m_filt, m_prev, m_flag;
    logic [2:0] m_hist;
    logic       m_sel, m_lvl, m_ev;
    logic [3:0] m_win;

    always @(posedge clk) begin
        if (rst) begin
            m_p1 = 0; m_p2 = 0; m_c1 = 0; m_c2 = 0;
            m_filt = 0; m_prev = 0; m_flag = 0; m_hist = 0;
        end else begin
            m_sel  = srcc ? m_c2 : m_p2;
            m_win  = {m_hist, m_sel};
            m_lvl  = filt ? m_filt : m_sel;
            m_ev   = rise ? (m_lvl & ~m_prev) : (~m_lvl & m_prev);
            m_flag = m_ev | (m_flag & ~(clr | ack));
            m_prev = m_lvl;
            if (m_win == 4'hF)      m_filt = 1'b1;
            else if (m_win == 4'h0) m_filt = 1'b0;
            m_hist = m_win[2:0];
            m_p2 = m_p1; m_p1 = pin;
            m_c2 = m_c1; m_c1 = cmp;
        end
    end

    function automatic logic exp_irq(logic f, logic en);
        return f & en;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic reset_all();
        rst = 1; pin = 0; cmp = 0; clr = 0; ack = 0;
        step(3);
        rst = 0;
        step(1);
    endtask

    task automatic pulse_clr();
        clr = 1; step(1); clr = 0;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1: reset state, with enables already on
        prot = 1; irqen = 1;
        reset_all();
        check("R1 flag after reset", flag, 1'b0);
        check("R1 irq after reset", irq, 1'b0);
        check("R1 shutdown after reset", sd, 1'b0);

        // R2: unfiltered rising edge latency
        prot = 0; irqen = 0; filt = 0; rise = 1; srcc = 0;
        reset_all();
        pin = 1;
        step(2); check("R2 flag not yet set", flag, 1'b0);
        step(1); check("R2 flag after three edges", flag, 1'b1);

        // R3: filtered latency, four clocks more
        filt = 1;
        reset_all();
        pin = 1;
        step(6); check("R3 filtered flag not yet set", flag, 1'b0);
        step(1); check("R3 filtered flag after seven edges", flag, 1'b1);

        // R3: three-sample glitch rejected, four-sample pulse accepted
        reset_all();
        pin = 1; step(3); pin = 0;
        step(12); check("R3 short glitch ignored", flag, 1'b0);
        pin = 1; step(4); pin = 0;
        step(10); check("R3 four-sample pulse accepted", flag, 1'b1);

        // R4: falling edge select ignores rising edges
        filt = 0; rise = 0;
        reset_all();
        pin = 1; step(5); check("R4 rise ignored in fall mode", flag, 1'b0);
        pin = 0; step(3); check("R4 fall sets flag", flag, 1'b1);

        // R5: comparator source; pin is ignored
        rise = 1; srcc = 1;
        reset_all();
        pin = 1; step(5); check("R5 pin ignored with comparator source", flag, 1'b0);
        cmp = 1; step(3); check("R5 comparator edge sets flag", flag, 1'b1);

        // R6: sticky flag, clear strobe and acknowledge
        step(5); check("R6 flag sticky", flag, 1'b1);
        pulse_clr(); check("R6 clear strobe", flag, 1'b0);
        cmp = 0; step(3); cmp = 1; step(3);
        check("R6 flag set again", flag, 1'b1);
        ack = 1; step(1); ack = 0;
        check("R6 acknowledge clears", flag, 1'b0);

        // R7: event and clear in the same cycle
        srcc = 0;
        reset_all();
        pin = 1; step(3); check("R7 setup flag set", flag, 1'b1);
        pin = 0; step(3);
        pin = 1; step(2);
        pulse_clr();
        check("R7 event wins over clear", flag, 1'b1);
        step(1); check("R7 flag still held", flag, 1'b1);
        pulse_clr(); check("R7 plain clear afterwards", flag, 1'b0);

        // R8 / R9: request gating
        reset_all();
        pin = 1; step(3);
        check("R8 irq masked", irq, 1'b0);
        check("R9 shutdown masked", sd, 1'b0);
        irqen = 1; step(1); check("R8 irq raised", irq, 1'b1);
        prot = 1;  step(1); check("R9 shutdown held", sd, 1'b1);
        pulse_clr();
        check("R8 irq dropped on clear", irq, 1'b0);
        check("R9 shutdown dropped on clear", sd, 1'b0);

        // Random phases against the reference model (R2..R9)
        for (int ph = 0; ph < 24; ph++) begin
            int run;
            prot  = 1'($urandom_range(0, 1));
            filt  = 1'($urandom_range(0, 1));
            rise  = 1'($urandom_range(0, 1));
            srcc  = 1'($urandom_range(0, 1));
            irqen = 1'($urandom_range(0, 1));
            run = 0;
            for (int c = 0; c < 250; c++) begin
                if (run == 0) begin
                    run = $urandom_range(1, 6);
                    if ($urandom_range(0, 1) == 1) pin = ~pin;
                    if ($urandom_range(0, 1) == 1) cmp = ~cmp;
                end
                run--;
                clr = ($urandom_range(0, 19) == 0);
                ack = ($urandom_range(0, 29) == 0);
                step(1);
                check("R6 random flag vs model", flag, m_flag);
                check("R8 random irq vs model", irq, exp_irq(m_flag, irqen));
                check("R9 random shutdown vs model", sd, m_flag & prot);
            end
            clr = 0; ack = 0;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule